// File: doc/BRIEF.md
# ADC Trigger and Status Controller

This block decides when an external analogue-to-digital converter starts a conversion, captures each finished 12-bit sample, and keeps two sticky, active-low ready flags with matching interrupt requests. Three start sources feed it. The first is a one-cycle software strobe. The second is an active-low external strobe. The third is the active-low output of a timer channel. Each source has its own static enable.

The two hardware lines are treated as a pulse. They are qualified by width: the block counts the clocks during which the line stays low, and starts a conversion on the release only when that count lies inside a legal window. A start request is dropped while a conversion is in flight. The result register changes only on the converter's done pulse. This lets software trigger the next conversion before it reads the previous sample.

A second timer output is watched for rising edges, which set the timer-ready flag. Register accesses arrive as one-cycle pulses: the sample high-byte read and the timer-clear write. Interrupt enables are static configuration levels. All inputs are assumed synchronous to `clk`.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After synchronous reset `start_o` is 0, `sample_o` is 0, both ready flags read 1 and both interrupt outputs read 0.
- R2: A `sw_strobe` pulse with `sw_en` high makes `start_o` high for exactly one cycle, in the cycle after the strobe. With `sw_en` low the strobe has no effect.
- R3: Let `ext_trig_n` be sampled low on N consecutive clock edges and then high. `start_o` pulses two cycles after the first high sample only when `ext_en` is 1 and MIN_CLK ≤ N ≤ MAX_CLK. Otherwise no start occurs.
- R4: The timer-A line `tmra_n` follows the same width rule as R3, gated by `tmra_en`.
- R5: Once `start_o` has pulsed, every further trigger is ignored until `conv_done` arrives. `start_o` is never high on two consecutive cycles.
- R6: `sample_o` loads `conv_data` in the cycle after `conv_done` and holds its value at all other times, including while a later conversion is running.
- R7: `adc_rdy_n` goes 0 in the cycle after `conv_done` and returns to 1 in the cycle after a `rd_hi` pulse. When both arrive in the same cycle, the flag goes to 0.
- R8: `tmr_rdy_n` goes 0 in the cycle after `tmrb` is first sampled high following a low sample. A level that stays high sets it only once. A `tmr_clr` pulse returns it to 1 and drops `irq_tmr`.
- R9: `irq_adc` and `irq_tmr` rise together with their flags only when `irq_adc_en` or `irq_tmr_en` respectively is 1. They then stay high until the matching read or clear. The flags update whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_en | input | 1 | Enable for the software strobe |
| ext_en | input | 1 | Enable for the external strobe |
| tmra_en | input | 1 | Enable for the timer-A line |
| sw_strobe | input | 1 | One-cycle software start request |
| ext_trig_n | input | 1 | External active-low start strobe |
| tmra_n | input | 1 | Timer-A active-low output |
| tmrb | input | 1 | Timer-B output, rising edge is the event |
| start_o | output | 1 | One-cycle start to the converter |
| conv_done | input | 1 | One-cycle conversion-finished pulse |
| conv_data | input | RES_W | Converter result bus |
| rd_hi | input | 1 | Pulse: sample high byte was read |
| tmr_clr | input | 1 | Pulse: timer-ready clear register written |
| irq_adc_en | input | 1 | Static enable for the conversion interrupt |
| irq_tmr_en | input | 1 | Static enable for the timer interrupt |
| sample_o | output | RES_W | Last captured conversion result |
| adc_rdy_n | output | 1 | Sticky active-low conversion-ready flag |
| tmr_rdy_n | output | 1 | Sticky active-low timer-ready flag |
| irq_adc | output | 1 | Conversion interrupt request level |
| irq_tmr | output | 1 | Timer interrupt request level |

## Verification
The bench builds the block with MIN_CLK = 3 and MAX_CLK = 8 in place of the default 13 and 300. This shrinks the legal window to a span that can be swept in full. Every low width from 1 to 11 clocks is driven on each hardware line, with that line's enable both on and off. The sweep covers both window edges, the saturating counter beyond MAX_CLK, and the exact start cycle. Directed sequences cover the busy lock, result hold across a second conversion, the same-cycle done and read collision, level-held timer edges and the disabled-interrupt cases.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
package adc_trig_pkg;
  // Defaults for a 50 MHz clock: 250 ns -> 13 clocks, 6 us -> 300 clocks
  parameter int DEF_MIN_CLK = 13;
  parameter int DEF_MAX_CLK = 300;
  parameter int DEF_RES_W   = 12;
  localparam int NUM_HW_SRC = 2;  // external strobe, timer A
endpackage

// File: rtl/trig_width_qual.sv
`timescale 1ns/1ps
module trig_width_qual #(
  parameter int MIN_CLK = 13,
  parameter int MAX_CLK = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic line_n,
  output logic fire
);
  localparam int CW = $clog2(MAX_CLK + 2);
  localparam logic [CW-1:0] SAT = CW'(MAX_CLK + 1);
  localparam logic [CW-1:0] LO  = CW'(MIN_CLK);
  localparam logic [CW-1:0] HI  = CW'(MAX_CLK);

  logic          line_q;
  logic [CW-1:0] low_cnt;
  logic          release_edge;

  assign release_edge = line_n && !line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= 1'b1;
      low_cnt <= '0;
      fire    <= 1'b0;
    end else begin
      line_q <= line_n;
      fire   <= en && release_edge && (low_cnt >= LO) && (low_cnt <= HI);
      if (!line_n)
        low_cnt <= (low_cnt == SAT) ? SAT : low_cnt + 1'b1;
      else
        low_cnt <= '0;
    end
  end

  // R3
  fire_after_release_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> line_q);
  // R4
  cnt_bounded_chk: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= SAT);
endmodule

// File: rtl/ready_flag.sv
`timescale 1ns/1ps
module ready_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  input  logic irq_en,
  output logic rdy_n,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdy_n <= 1'b1;
      irq   <= 1'b0;
    end else if (evt) begin
      rdy_n <= 1'b0;
      irq   <= irq | irq_en;
    end else if (clr) begin
      rdy_n <= 1'b1;
      irq   <= 1'b0;
    end
  end

  // R7
  flag_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rdy_n) |-> $past(evt));
  // R8
  flag_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_n) |-> $past(clr));
  // R9
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> !rdy_n);
endmodule

// File: rtl/adc_trig_ctrl.sv
`timescale 1ns/1ps
module adc_trig_ctrl
  import adc_trig_pkg::*;
#(
  parameter int MIN_CLK = DEF_MIN_CLK,
  parameter int MAX_CLK = DEF_MAX_CLK,
  parameter int RES_W   = DEF_RES_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_en,
  input  logic             ext_en,
  input  logic             tmra_en,
  input  logic             sw_strobe,
  input  logic             ext_trig_n,
  input  logic             tmra_n,
  input  logic             tmrb,
  output logic             start_o,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic             rd_hi,
  input  logic             tmr_clr,
  input  logic             irq_adc_en,
  input  logic             irq_tmr_en,
  output logic [RES_W-1:0] sample_o,
  output logic             adc_rdy_n,
  output logic             tmr_rdy_n,
  output logic             irq_adc,
  output logic             irq_tmr
);
  logic [NUM_HW_SRC-1:0] hw_line, hw_en, hw_fire;
  logic                  busy, req, tmrb_q, tmrb_rise;

  assign hw_line = {tmra_n, ext_trig_n};
  assign hw_en   = {tmra_en, ext_en};

  for (genvar g = 0; g < NUM_HW_SRC; g++) begin : g_qual
    trig_width_qual #(.MIN_CLK(MIN_CLK), .MAX_CLK(MAX_CLK)) u_qual (
      .clk(clk), .rst(rst), .en(hw_en[g]), .line_n(hw_line[g]), .fire(hw_fire[g]));
  end

  assign req = (sw_strobe && sw_en) || (|hw_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o  <= 1'b0;
      busy     <= 1'b0;
      sample_o <= '0;
      tmrb_q   <= 1'b1;
    end else begin
      start_o <= req && !busy && !start_o;
      if (start_o)        busy <= 1'b1;
      else if (conv_done) busy <= 1'b0;
      if (conv_done) sample_o <= conv_data;
      tmrb_q <= tmrb;
    end
  end

  assign tmrb_rise = tmrb && !tmrb_q;

  ready_flag u_adc_flag (
    .clk(clk), .rst(rst), .evt(conv_done), .clr(rd_hi), .irq_en(irq_adc_en),
    .rdy_n(adc_rdy_n), .irq(irq_adc));

  ready_flag u_tmr_flag (
    .clk(clk), .rst(rst), .evt(tmrb_rise), .clr(tmr_clr), .irq_en(irq_tmr_en),
    .rdy_n(tmr_rdy_n), .irq(irq_tmr));

  // R5
  no_double_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);
  // R6
  sample_only_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sample_o) |-> $past(conv_done));
endmodule

// File: tb/tb_adc_trig_ctrl.sv
`timescale 1ns/1ps
module tb_adc_trig_ctrl;
  localparam int MINC = 3;
  localparam int MAXC = 8;
  localparam int RW   = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_en = 0, ext_en = 0, tmra_en = 0, sw_strobe = 0;
  logic ext_trig_n = 1, tmra_n = 1, tmrb = 0;
  logic conv_done = 0, rd_hi = 0, tmr_clr = 0;
  logic irq_adc_en = 0, irq_tmr_en = 0;
  logic [RW-1:0] conv_data = '0;
  logic start_o, adc_rdy_n, tmr_rdy_n, irq_adc, irq_tmr;
  logic [RW-1:0] sample_o;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_trig_ctrl #(.MIN_CLK(MINC), .MAX_CLK(MAXC), .RES_W(RW)) dut (
    .clk(clk), .rst(rst), .sw_en(sw_en), .ext_en(ext_en), .tmra_en(tmra_en),
    .sw_strobe(sw_strobe), .ext_trig_n(ext_trig_n), .tmra_n(tmra_n), .tmrb(tmrb),
    .start_o(start_o), .conv_done(conv_done), .conv_data(conv_data), .rd_hi(rd_hi),
    .tmr_clr(tmr_clr), .irq_adc_en(irq_adc_en), .irq_tmr_en(irq_tmr_en),
    .sample_o(sample_o), .adc_rdy_n(adc_rdy_n), .tmr_rdy_n(tmr_rdy_n),
    .irq_adc(irq_adc), .irq_tmr(irq_tmr));

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic sw_pulse(output int seen);
    @(negedge clk) sw_strobe = 1;
    @(negedge clk) sw_strobe = 0;
    seen = int'(start_o);
  endtask

  task automatic hw_pulse(input int which, input int n, output int at1, output int at2);
    @(negedge clk);
    if (which == 0) ext_trig_n = 0; else tmra_n = 0;
    repeat (n) @(negedge clk);
    ext_trig_n = 1; tmra_n = 1;
    @(negedge clk) at1 = int'(start_o);
    @(negedge clk) at2 = int'(start_o);
    @(negedge clk);
  endtask

  task automatic finish_conv(input int d, input string tag);
    @(negedge clk) begin conv_done = 1; conv_data = RW'(d); end
    @(negedge clk) conv_done = 0;
    chk({tag, " R6 sample"}, int'(sample_o), d & 12'hFFF);
    chk({tag, " R7 flag low"}, int'(adc_rdy_n), 0);
    chk({tag, " R9 irq_adc"}, int'(irq_adc), int'(irq_adc_en));
  endtask

  task automatic read_hi(input string tag);
    @(negedge clk) rd_hi = 1;
    @(negedge clk) rd_hi = 0;
    chk({tag, " R7 flag back high"}, int'(adc_rdy_n), 1);
    chk({tag, " R9 irq_adc dropped"}, int'(irq_adc), 0);
  endtask

  initial begin
    int a1, a2, s;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 start", int'(start_o), 0);
    chk("R1 sample", int'(sample_o), 0);
    chk("R1 adc_rdy_n", int'(adc_rdy_n), 1);
    chk("R1 tmr_rdy_n", int'(tmr_rdy_n), 1);
    chk("R1 irqs", int'(irq_adc) + int'(irq_tmr), 0);

    irq_adc_en = 1; irq_tmr_en = 1;

    // R2 software strobe, enabled and disabled
    sw_en = 0;
    sw_pulse(s); chk("R2 disabled strobe", s, 0);
    sw_en = 1;
    sw_pulse(s); chk("R2 enabled strobe", s, 1);
    @(negedge clk) chk("R2 single cycle", int'(start_o), 0);
    finish_conv(12'h5A5, "R2");
    read_hi("R2");
    sw_en = 0;

    // R3 / R4 width sweep on both hardware lines
    for (int which = 0; which < 2; which++) begin
      for (int en = 0; en < 2; en++) begin
        for (int n = 1; n <= 11; n++) begin
          int exp;
          string tag;
          tag = (which == 0) ? "R3" : "R4";
          ext_en = (which == 0) ? en[0] : 1'b0;
          tmra_en = (which == 1) ? en[0] : 1'b0;
          exp = (en == 1 && n >= MINC && n <= MAXC) ? 1 : 0;
          hw_pulse(which, n, a1, a2);
          chk($sformatf("%s width %0d en %0d early", tag, n, en), a1, 0);
          chk($sformatf("%s width %0d en %0d start", tag, n, en), a2, exp);
          if (exp == 1) begin
            finish_conv(n * 97 + which, tag);
            read_hi(tag);
          end
        end
      end
    end

    // R5 busy lock
    ext_en = 1; tmra_en = 0; sw_en = 1;
    sw_pulse(s); chk("R5 first start", s, 1);
    sw_pulse(s); chk("R5 sw while busy", s, 0);
    hw_pulse(0, 5, a1, a2); chk("R5 hw while busy", a2, 0);
    finish_conv(12'hABC, "R5");
    // R6 hold across a new conversion
    sw_pulse(s); chk("R5 start after done", s, 1);
    repeat (3) @(negedge clk);
    chk("R6 hold during conversion", int'(sample_o), 12'hABC);
    finish_conv(12'h123, "R6");
    read_hi("R6");

    // R7 done and read in the same cycle
    sw_pulse(s); chk("R7 start", s, 1);
    @(negedge clk) begin conv_done = 1; rd_hi = 1; conv_data = 12'h777; end
    @(negedge clk) begin conv_done = 0; rd_hi = 0; end
    chk("R7 collision keeps flag low", int'(adc_rdy_n), 0);
    read_hi("R7");

    // R9 disabled conversion interrupt
    irq_adc_en = 0;
    sw_pulse(s); chk("R9 start", s, 1);
    finish_conv(12'h0F0, "R9 disabled");
    read_hi("R9");
    irq_adc_en = 1;

    // R8 / R9 timer-B edge
    @(negedge clk) tmrb = 1;
    @(negedge clk);
    chk("R8 timer flag set", int'(tmr_rdy_n), 0);
    chk("R9 irq_tmr set", int'(irq_tmr), 1);
    tmrb = 0;
    repeat (3) @(negedge clk);
    chk("R9 irq_tmr held", int'(irq_tmr), 1);
    chk("R8 flag held", int'(tmr_rdy_n), 0);
    @(negedge clk) tmr_clr = 1;
    @(negedge clk) tmr_clr = 0;
    chk("R8 clear flag", int'(tmr_rdy_n), 1);
    chk("R8 clear irq", int'(irq_tmr), 0);
    // level held high sets only once
    @(negedge clk) tmrb = 1;
    @(negedge clk) tmr_clr = 1;
    @(negedge clk) tmr_clr = 0;
    repeat (3) @(negedge clk);
    chk("R8 level held no re-set", int'(tmr_rdy_n), 1);
    tmrb = 0;
    irq_tmr_en = 0;
    @(negedge clk) tmrb = 1;
    @(negedge clk);
    chk("R9 flag without irq", int'(tmr_rdy_n), 0);
    chk("R9 irq_tmr disabled", int'(irq_tmr), 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule